// File: doc/BRIEF.md
# Receiver Electrical Idle Detector

This block tells the receive datapath whether the far-end transmitter is sending data or has gone into electrical idle. Its only evidence is the lock-to-data status of the receiver's clock-data-recovery unit. That status is asynchronous to the local clock. While valid data arrives it sits high. While no valid data is present it toggles with no predictable period. The lock-to-reference status is not trustworthy for this purpose, so the block does not take it as an input.

The lock-to-data input first passes through a flop synchronizer. A saturating run-length counter then measures how long the synchronized status has stayed high without a break. Leaving idle needs an unbroken high run equal to the qualification time, which is given in clock cycles and derived from the clock frequency and the minimum time (4 µs by default). Entering idle needs only one low sample once the link is active. The same decision drives a hold-in-reset output for the downstream receive PCS. The block also emits one-cycle event pulses on entry and on exit.

Top module: `rx_eidle_detect`

## Requirements
- R1: A change on `ltd_async_i` has no effect on any output before the third rising clock edge that follows it. This comes from the two-flop input synchronizer.
- R2: While reset is applied and just after it is released, the block reports idle: `eidle_o`=1 and `pcs_rst_o`=1, with `eidle_enter_o`=0 and `eidle_exit_o`=0.
- R3: If `ltd_async_i` rises and then stays high, `eidle_o` falls on rising edge Q+3, where Q is the qualification count. The edge that first samples the high input is edge 1.
- R4: Any low synchronized sample restarts the qualification from zero. A high run shorter than Q cycles never clears `eidle_o`, however often such runs repeat.
- R5: While the link is active, a low on `ltd_async_i` sets `eidle_o` on the third rising edge after the change.
- R6: `eidle_exit_o` is high for exactly one cycle: the cycle in which `eidle_o` first reads 0. `eidle_enter_o` is high for exactly one cycle: the cycle in which `eidle_o` first reads 1 after being active. The two pulses are never high together.
- R7: `pcs_rst_o` is high in every cycle in which `eidle_o` is high. It is released in the same cycle as the exit pulse and reasserted in the same cycle as the entry pulse.
- R8: The qualification counter saturates at Q. An arbitrarily long active period produces no further events and keeps `eidle_o`=0.
- R9: Q is CLK_FREQ_KHZ × MIN_TIME_NS / 10^6, rounded up to a whole cycle, with a minimum of 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Local receive clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| ltd_async_i | input | 1 | Lock-to-data status from clock-data recovery, asynchronous |
| eidle_o | output | 1 | High while the far-end transmitter is considered in electrical idle |
| eidle_enter_o | output | 1 | One-cycle pulse on entry into electrical idle |
| eidle_exit_o | output | 1 | One-cycle pulse on exit from electrical idle |
| pcs_rst_o | output | 1 | Hold-in-reset for the receive PCS logic |

## Verification
The bench builds the block with a 250 MHz clock and a 62 ns minimum time. That gives 15.5 cycles, which must round up to Q=16. The measured exit latency therefore shows whether the rounding is correct. With the qualification window this short, the bench can run many idle/active round trips within a few thousand cycles. It can also place high runs of exactly Q-1 and exactly Q cycles. Long active stretches of several thousand cycles exercise counter saturation, well past its 5-bit range.

// File: rtl/ed_pkg.sv
package ed_pkg;

  typedef enum logic {
    LS_IDLE   = 1'b0,
    LS_ACTIVE = 1'b1
  } link_state_e;

  // Whole cycles covering min_ns at clk_khz, rounded up, at least one.
  function automatic longint unsigned qual_cycles(input longint unsigned clk_khz,
                                                  input longint unsigned min_ns);
    longint unsigned c;
    c = (clk_khz * min_ns + 64'd999_999) / 64'd1_000_000;
    if (c == 0) c = 1;
    return c;
  endfunction

endpackage

// File: rtl/ed_sync_chain.sv
module ed_sync_chain #(
  parameter int unsigned STAGES    = 2,
  parameter bit          RESET_VAL = 1'b0
) (
  input  logic clk,
  input  logic arst_n,
  input  logic d_i,
  output logic q_o
);

  logic [STAGES-1:0] stage_q;

  generate
    for (genvar g = 0; g < STAGES; g++) begin : g_stage
      if (g == 0) begin : g_first
        always_ff @(posedge clk or negedge arst_n) begin
          if (!arst_n) stage_q[0] <= RESET_VAL;
          else         stage_q[0] <= d_i;
        end
      end else begin : g_next
        always_ff @(posedge clk or negedge arst_n) begin
          if (!arst_n) stage_q[g] <= RESET_VAL;
          else         stage_q[g] <= stage_q[g-1];
        end
      end
    end
  endgenerate

  assign q_o = stage_q[STAGES-1];

endmodule

// File: rtl/ed_qual_timer.sv
module ed_qual_timer #(
  parameter int unsigned QUAL_CYCLES = 1000,
  localparam int unsigned CW = $clog2(QUAL_CYCLES + 1)
) (
  input  logic clk,
  input  logic arst_n,
  input  logic level_i,
  output logic qualified_o
);

  localparam logic [CW-1:0] LIMIT = CW'(QUAL_CYCLES);

  logic [CW-1:0] cnt_q, cnt_d;
  logic          cnt_en;

  // Counting is enabled only while the level is high and the limit is not reached.
  assign cnt_en = level_i && (cnt_q != LIMIT);

  always_comb begin
    cnt_d = cnt_q;
    if (!level_i)    cnt_d = '0;
    else if (cnt_en) cnt_d = cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) cnt_q <= '0;
    else         cnt_q <= cnt_d;
  end

  assign qualified_o = (cnt_q == LIMIT);

  p_cnt_bounded_r8: assert property (@(posedge clk) disable iff (!arst_n)
    cnt_q <= LIMIT);

  p_low_restarts_r4: assert property (@(posedge clk) disable iff (!arst_n)
    !level_i |=> (cnt_q == '0));

  p_saturate_hold_r8: assert property (@(posedge clk) disable iff (!arst_n)
    (level_i && qualified_o) |=> qualified_o);

endmodule

// File: rtl/ed_link_fsm.sv
module ed_link_fsm (
  input  logic clk,
  input  logic arst_n,
  input  logic level_i,
  input  logic qualified_i,
  output logic idle_o,
  output logic enter_o,
  output logic exit_o,
  output logic pcs_rst_o
);

  import ed_pkg::*;

  link_state_e state_q, state_d;
  logic        enter_q, enter_d;
  logic        exit_q,  exit_d;
  logic        prst_q,  prst_d;

  always_comb begin
    state_d = state_q;
    enter_d = 1'b0;
    exit_d  = 1'b0;
    unique case (state_q)
      LS_IDLE: begin
        if (qualified_i) begin
          state_d = LS_ACTIVE;
          exit_d  = 1'b1;
        end
      end
      LS_ACTIVE: begin
        if (!level_i) begin
          state_d = LS_IDLE;
          enter_d = 1'b1;
        end
      end
      default: state_d = LS_IDLE;
    endcase
    prst_d = (state_d == LS_IDLE);
  end

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) begin
      state_q <= LS_IDLE;
      enter_q <= 1'b0;
      exit_q  <= 1'b0;
      prst_q  <= 1'b1;
    end else begin
      state_q <= state_d;
      enter_q <= enter_d;
      exit_q  <= exit_d;
      prst_q  <= prst_d;
    end
  end

  assign idle_o    = (state_q == LS_IDLE);
  assign enter_o   = enter_q;
  assign exit_o    = exit_q;
  assign pcs_rst_o = prst_q;

  p_exit_after_qual_r3: assert property (@(posedge clk) disable iff (!arst_n)
    $rose(exit_q) |-> $past(qualified_i));

  p_enter_on_low_r5: assert property (@(posedge clk) disable iff (!arst_n)
    (!idle_o && !level_i) |=> (idle_o && enter_q));

  p_exit_single_r6: assert property (@(posedge clk) disable iff (!arst_n)
    exit_q |=> !exit_q);

  p_enter_single_r6: assert property (@(posedge clk) disable iff (!arst_n)
    enter_q |=> !enter_q);

  p_no_dual_pulse_r6: assert property (@(posedge clk) disable iff (!arst_n)
    !(enter_q && exit_q));

  p_release_with_exit_r7: assert property (@(posedge clk) disable iff (!arst_n)
    $fell(prst_q) |-> exit_q);

  p_rst_while_idle_r7: assert property (@(posedge clk) disable iff (!arst_n)
    idle_o |-> prst_q);

endmodule

// File: rtl/rx_eidle_detect.sv
module rx_eidle_detect #(
  parameter int unsigned CLK_FREQ_KHZ = 250000,
  parameter int unsigned MIN_TIME_NS  = 4000,
  parameter int unsigned SYNC_STAGES  = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic ltd_async_i,
  output logic eidle_o,
  output logic eidle_enter_o,
  output logic eidle_exit_o,
  output logic pcs_rst_o
);

  localparam int unsigned QUAL_CYCLES =
    int'(ed_pkg::qual_cycles(longint'(CLK_FREQ_KHZ), longint'(MIN_TIME_NS)));

  logic rst_sync_n;
  logic ltd_sync;
  logic qualified;

  // Reset: asserted asynchronously, released on the clock.
  ed_sync_chain #(.STAGES(2), .RESET_VAL(1'b0)) u_rst_sync (
    .clk    (clk),
    .arst_n (rst_n),
    .d_i    (1'b1),
    .q_o    (rst_sync_n)
  );

  ed_sync_chain #(.STAGES(SYNC_STAGES), .RESET_VAL(1'b0)) u_ltd_sync (
    .clk    (clk),
    .arst_n (rst_sync_n),
    .d_i    (ltd_async_i),
    .q_o    (ltd_sync)
  );

  ed_qual_timer #(.QUAL_CYCLES(QUAL_CYCLES)) u_timer (
    .clk         (clk),
    .arst_n      (rst_sync_n),
    .level_i     (ltd_sync),
    .qualified_o (qualified)
  );

  ed_link_fsm u_fsm (
    .clk         (clk),
    .arst_n      (rst_sync_n),
    .level_i     (ltd_sync),
    .qualified_i (qualified),
    .idle_o      (eidle_o),
    .enter_o     (eidle_enter_o),
    .exit_o      (eidle_exit_o),
    .pcs_rst_o   (pcs_rst_o)
  );

  p_reset_idle_r2: assert property (@(posedge clk) disable iff (!rst_sync_n)
    $rose(rst_sync_n) |-> (eidle_o && pcs_rst_o && !eidle_exit_o && !eidle_enter_o));

endmodule

// File: tb/rx_eidle_detect_tb_top.sv
`timescale 1ns/1ps
module rx_eidle_detect_tb_top;

  localparam int unsigned FREQ_KHZ = 250000;
  localparam int unsigned MIN_NS   = 62;

  function automatic int exp_qual(input longint f, input longint t);
    longint c;
    c = (f * t + 999999) / 1000000;
    return (c < 1) ? 1 : int'(c);
  endfunction

  localparam int Q = exp_qual(FREQ_KHZ, MIN_NS);

  logic clk = 1'b0;
  logic rst_n;
  logic ltd;
  logic eidle, enter_p, exit_p, prst;

  int checks = 0;
  int errors = 0;
  bit chk_en = 1'b0;
  bit done   = 1'b0;

  always #2 clk = ~clk;

  rx_eidle_detect #(.CLK_FREQ_KHZ(FREQ_KHZ), .MIN_TIME_NS(MIN_NS)) dut_i (
    .clk           (clk),
    .rst_n         (rst_n),
    .ltd_async_i   (ltd),
    .eidle_o       (eidle),
    .eidle_enter_o (enter_p),
    .eidle_exit_o  (exit_p),
    .pcs_rst_o     (prst)
  );

  task automatic chk(input bit ok, input string tag, input int act, input int expv);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, expv, $time);
    end
  endtask

  // Reference model built from the requirements.
  function automatic int run_next(input bit hi, input int run);
    if (!hi) return 0;
    return (run < Q) ? run + 1 : run;
  endfunction

  logic m_r1, m_r2, m_s1, m_s2, m_idle, m_en, m_ex, m_rst;
  int   m_run;

  always @(posedge clk or negedge rst_n)
    if (!rst_n) begin m_r1 <= 1'b0; m_r2 <= 1'b0; end
    else        begin m_r1 <= 1'b1; m_r2 <= m_r1; end

  always @(posedge clk or negedge m_r2)
    if (!m_r2) begin
      m_s1 <= 0; m_s2 <= 0; m_run <= 0;
      m_idle <= 1; m_en <= 0; m_ex <= 0; m_rst <= 1;
    end else begin
      m_s1  <= ltd;
      m_s2  <= m_s1;
      m_run <= run_next(m_s2, m_run);
      m_en  <= 0;
      m_ex  <= 0;
      if (m_idle && m_run == Q) begin
        m_idle <= 0; m_ex <= 1; m_rst <= 0;
      end else if (!m_idle && !m_s2) begin
        m_idle <= 1; m_en <= 1; m_rst <= 1;
      end
    end

  always @(negedge clk)
    if (chk_en) begin
      chk(eidle == m_idle, "R3/R5 model eidle", eidle, m_idle);
      chk(exit_p == m_ex, "R6 model exit pulse", exit_p, m_ex);
      chk(enter_p == m_en, "R6 model entry pulse", enter_p, m_en);
      chk(prst == m_rst, "R7 model pcs reset", prst, m_rst);
      chk(!(eidle && !prst), "R7 reset while idle", prst, 1);
    end

  task automatic cycles(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic wait_eidle(input logic target, output int n);
    n = 0;
    do begin
      @(negedge clk);
      n++;
    end while (eidle != target && n < 5000);
  endtask

  initial begin
    #(4 * 190000);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("  Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    int n;
    bit stay_idle;
    void'($urandom(32'd20240611));
    rst_n = 1'b0;
    ltd   = 1'b0;
    cycles(5);
    // R2: held in reset
    chk(eidle == 1, "R2 reset eidle", eidle, 1);
    chk(prst == 1, "R2 reset pcs_rst", prst, 1);
    chk(enter_p == 0 && exit_p == 0, "R2 reset pulses", enter_p | exit_p, 0);
    rst_n = 1'b1;
    cycles(4);
    chk(eidle == 1 && prst == 1, "R2 after release idle", eidle, 1);
    chk_en = 1'b1;

    // R4: repeated runs of Q-1 highs never exit
    stay_idle = 1'b1;
    for (int k = 0; k < 20; k++) begin
      ltd = 1'b1;
      for (int i = 0; i < Q - 1; i++) begin
        @(negedge clk);
        if (!eidle) stay_idle = 1'b0;
      end
      ltd = 1'b0;
      for (int i = 0; i < 1 + (k % 3); i++) begin
        @(negedge clk);
        if (!eidle) stay_idle = 1'b0;
      end
    end
    cycles(4);
    chk(stay_idle && eidle, "R4 short highs stay idle", eidle, 1);

    // R3, R9: exit latency Q+3 edges with rounded Q
    ltd = 1'b1;
    wait_eidle(1'b0, n);
    chk(n == Q + 3, "R3 exit latency", n, Q + 3);
    chk(n == 16 + 3, "R9 rounded qualification", n, 19);
    chk(exit_p == 1, "R6 exit pulse with flag", exit_p, 1);
    chk(prst == 0, "R7 pcs released with exit", prst, 0);
    @(negedge clk);
    chk(exit_p == 0, "R6 exit pulse one cycle", exit_p, 0);

    // R8: long active period, no events
    stay_idle = 1'b0;
    for (int i = 0; i < 3000; i++) begin
      @(negedge clk);
      if (eidle || enter_p || exit_p) stay_idle = 1'b1;
    end
    chk(!stay_idle, "R8 long active no events", stay_idle, 0);

    // R1, R5: entry latency of three edges
    ltd = 1'b0;
    wait_eidle(1'b1, n);
    chk(n == 3, "R5 entry latency", n, 3);
    chk(n >= 3, "R1 no effect before third edge", n, 3);
    chk(enter_p == 1, "R6 entry pulse with flag", enter_p, 1);
    chk(prst == 1, "R7 pcs reasserted with entry", prst, 1);
    @(negedge clk);
    chk(enter_p == 0, "R6 entry pulse one cycle", enter_p, 0);

    // R3 boundary: exactly Q highs are enough
    ltd = 1'b1;
    cycles(Q);
    ltd = 1'b0;
    n = 0;
    for (int i = 0; i < 6; i++) begin
      @(negedge clk);
      if (exit_p) n++;
    end
    chk(n == 1, "R3 exactly Q highs exit once", n, 1);
    cycles(4);

    // Random mix checked against the model
    for (int k = 0; k < 600; k++) begin
      int hl, ll;
      if ($urandom_range(0, 3) == 0) hl = $urandom_range(Q, Q + 40);
      else                            hl = $urandom_range(1, Q - 1);
      ll = $urandom_range(1, 10);
      ltd = 1'b1; cycles(hl);
      ltd = 1'b0; cycles(ll);
    end
    cycles(5);
    chk(eidle == 1, "R5 ends idle after low", eidle, 1);

    chk_en = 1'b0;
    done = 1'b1;
    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule